// File: doc/BRIEF.md
# Cycle-Stealing Single-Channel DMA Engine

This block copies a run of words from one memory region to another over a bus it shares with the processor. Software loads a source pointer, a destination pointer and a word count, then writes a start command. The engine then moves the words one at a time. For each word it asks for the bus, reads the source word into an internal holding register, writes that register to the destination, and then gives the bus back to the processor for at least one cycle. The processor only loses the bus for the cycles it actually grants.

When the final word has been written, the engine goes idle and raises an interrupt. The interrupt stays asserted until software clears it. A start with a count of zero finishes at once: it raises the interrupt and makes no bus request.

**Bus handshake.** The bus side works like a valid/ready pair. `bus_req` acts as the valid and `bus_gnt` as the ready, and an access completes in any cycle where both are high. While the grant is withheld (back-pressure), the request stays high and the pending access stays the same. `bus_rdata` must hold the addressed word during a granted read cycle. Address, write strobe and write data are driven only in cycles where both request and grant are high, and are zero otherwise.

Top module: `dma_steal`

## Requirements
- R1: After reset:
  - the engine is idle;
  - `bus_req` is low;
  - the interrupt is low;
  - the source, destination and count registers read as zero.
- R2: Register offsets on `cfg_addr`:
  - 0 is the source pointer;
  - 1 is the destination pointer;
  - 2 is the word count;
  - 3 is control/status.

  Pointers and count read back on `cfg_rdata`. At offset 3, bit 0 reads as busy and bit 1 reads as the interrupt.
- R3: A write to offset 3 with bit 0 set, made while idle with a nonzero count, sets busy from the next cycle and raises `bus_req`.
- R4: Each word uses two granted accesses, in this order:
  - a read (`bus_we`=0) at the current source pointer;
  - then a write (`bus_we`=1) at the current destination pointer, whose data is the word that was read.
- R5: After a granted write access, `bus_req` is low in the following cycle, so only one word is moved per bus acquisition.
- R6: A request that is not granted stays asserted in the next cycle.
- R7: In every cycle where `bus_gnt` is low, `bus_addr`, `bus_we` and `bus_wdata` are all zero.
- R8: After each word, both pointers increase by one and the count decreases by one. After a transfer of N words, the pointers read as their start values plus N and the count reads as zero.
- R9: On the edge of the last granted write, busy clears and the interrupt sets.
- R10: Configuration writes made while busy are ignored, including a repeated start. The pointers and count keep following the transfer.
- R11: A start with a count of zero sets the interrupt on the next cycle, leaves busy low and makes no bus request.
- R12: The interrupt stays asserted until a write to offset 3 with bit 1 set. A write to offset 3 with bit 1 clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register offset |
| cfg_wdata | input | DW | Configuration write data |
| cfg_rdata | output | DW | Configuration read data for `cfg_addr` (combinational) |
| irq | output | 1 | Completion interrupt, level |
| bus_req | output | 1 | Bus request (valid) |
| bus_gnt | input | 1 | Bus grant (ready) |
| bus_we | output | 1 | Write strobe for a granted access |
| bus_addr | output | AW | Address for a granted access |
| bus_wdata | output | DW | Write data for a granted write |
| bus_rdata | input | DW | Read data during a granted read |

## Verification
The embedded assertions check the following on every cycle:
- the bus is released after each write access;
- a granted read is always followed by the write of the same word;
- an ungranted request is held;
- the interrupt never rises while busy;
- busy implies a nonzero count;
- the registers stay frozen against configuration writes while busy.

Some behaviours can only be shown by the bench's transfers under random grant patterns:
- that the right addresses are accessed in order;
- that the destination ends up holding the source data;
- the zero-count case;
- that configuration writes made during a transfer do not disturb it.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_GAP  = 2'd3
  } dma_state_e;

  localparam logic [1:0] OFS_SRC = 2'd0;
  localparam logic [1:0] OFS_DST = 2'd1;
  localparam logic [1:0] OFS_CNT = 2'd2;
  localparam logic [1:0] OFS_CTL = 2'd3;

  localparam int CTL_GO_BIT   = 0;
  localparam int CTL_ACK_BIT  = 1;
  localparam int STS_BUSY_BIT = 0;
  localparam int STS_IRQ_BIT  = 1;

endpackage

// File: rtl/dma_steal_regs.sv
module dma_steal_regs
  import dma_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic          busy,
  input  logic          step,
  output logic [AW-1:0] src_ptr,
  output logic [AW-1:0] dst_ptr,
  output logic [CW-1:0] words_left
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_ptr    <= '0;
      dst_ptr    <= '0;
      words_left <= '0;
    end else if (step) begin
      src_ptr    <= src_ptr + AW'(1);
      dst_ptr    <= dst_ptr + AW'(1);
      words_left <= words_left - CW'(1);
    end else if (cfg_we && !busy) begin
      case (cfg_addr)
        OFS_SRC: src_ptr    <= cfg_wdata[AW-1:0];
        OFS_DST: dst_ptr    <= cfg_wdata[AW-1:0];
        OFS_CNT: words_left <= cfg_wdata[CW-1:0];
        default: ;
      endcase
    end
  end

  // R10
  frozen_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step) |=> ($stable(src_ptr) && $stable(dst_ptr) && $stable(words_left)));

  // R8
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (src_ptr == $past(src_ptr) + AW'(1)) && (words_left == $past(words_left) - CW'(1)));

endmodule

// File: rtl/dma_steal_seq.sv
module dma_steal_seq
  import dma_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          irq_ack,
  input  logic [AW-1:0] src_ptr,
  input  logic [AW-1:0] dst_ptr,
  input  logic [CW-1:0] words_left,
  input  logic          bus_gnt,
  input  logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          irq,
  output logic          step,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);

  dma_state_e    state_q, state_d;
  logic [DW-1:0] hold_q;
  logic          rd_hit, wr_hit, last_word, zero_go;

  always_comb begin
    bus_req   = (state_q == ST_RD) || (state_q == ST_WR);
    rd_hit    = (state_q == ST_RD) && bus_gnt;
    wr_hit    = (state_q == ST_WR) && bus_gnt;
    step      = wr_hit;
    busy      = (state_q != ST_IDLE);
    last_word = (words_left == CW'(1));
    zero_go   = go && (words_left == '0);
    bus_we    = wr_hit;
    bus_wdata = wr_hit ? hold_q : '0;
    if (rd_hit)      bus_addr = src_ptr;
    else if (wr_hit) bus_addr = dst_ptr;
    else             bus_addr = '0;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go && !zero_go) state_d = ST_RD;
      ST_RD:   if (bus_gnt) state_d = ST_WR;
      ST_WR:   if (bus_gnt) state_d = last_word ? ST_IDLE : ST_GAP;
      ST_GAP:  state_d = ST_RD;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      irq     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (rd_hit) hold_q <= bus_rdata;
      if ((zero_go && !busy) || (wr_hit && last_word)) irq <= 1'b1;
      else if (irq_ack)                                irq <= 1'b0;
    end
  end

  // R5
  release_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && bus_we) |=> !bus_req);

  // R4
  read_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !bus_we) |=> (bus_req && (!bus_gnt || bus_we)));

  // R6
  hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req);

  // R9
  irq_only_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !busy);

  // R11
  busy_needs_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (words_left != '0));

endmodule

// File: rtl/dma_steal.sv
module dma_steal
  import dma_steal_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          irq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata
);

  logic [AW-1:0] src_ptr, dst_ptr;
  logic [CW-1:0] words_left;
  logic          busy, step, go, irq_ack, ctl_wr;

  assign ctl_wr  = cfg_we && (cfg_addr == OFS_CTL);
  assign go      = ctl_wr && cfg_wdata[CTL_GO_BIT] && !busy;
  assign irq_ack = ctl_wr && cfg_wdata[CTL_ACK_BIT];

  dma_steal_regs #(.AW(AW), .DW(DW), .CW(CW)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(busy), .step(step),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .words_left(words_left)
  );

  dma_steal_seq #(.AW(AW), .DW(DW), .CW(CW)) seq_i (
    .clk(clk), .rst_n(rst_n), .go(go), .irq_ack(irq_ack),
    .src_ptr(src_ptr), .dst_ptr(dst_ptr), .words_left(words_left),
    .bus_gnt(bus_gnt), .bus_rdata(bus_rdata),
    .busy(busy), .irq(irq), .step(step),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
  );

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      OFS_SRC: cfg_rdata[AW-1:0] = src_ptr;
      OFS_DST: cfg_rdata[AW-1:0] = dst_ptr;
      OFS_CNT: cfg_rdata[CW-1:0] = words_left;
      default: begin
        cfg_rdata[STS_BUSY_BIT] = busy;
        cfg_rdata[STS_IRQ_BIT]  = irq;
      end
    endcase
  end

  // R7
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_gnt |-> (bus_addr == '0 && !bus_we && bus_wdata == '0));

endmodule

// File: tb/dma_steal_tb.sv
module dma_steal_tb_top;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = 2'd0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [DW-1:0] cfg_rdata;
  logic          irq, bus_req, bus_we;
  logic          bus_gnt = 1'b1;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;

  logic [DW-1:0] mem  [0:255];
  logic [DW-1:0] snap [0:255];

  int checks = 0;
  int fails  = 0;
  bit rand_gnt = 0;
  bit no_req = 0;
  bit after_wr = 0;
  bit stall_prev = 0;
  int rd_ptr = 0;
  int wr_ptr = 0;
  logic [DW-1:0] pend = '0;

  always #10 clk = ~clk;

  assign bus_rdata = mem[bus_addr[7:0]];

  dma_steal #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) bus_gnt <= rand_gnt ? (($urandom % 4) != 0) : 1'b1;

  // bus monitor and memory model, sampled mid low phase
  always begin
    @(negedge clk);
    #5;
    if (rst_n) begin
      if (after_wr) chk(!bus_req, "R5", "req after word", bus_req, 0);
      after_wr = 0;
      if (stall_prev) chk(bus_req, "R6", "req held while stalled", bus_req, 1);
      stall_prev = bus_req && !bus_gnt;
      if (no_req) chk(!bus_req, "R11", "req on zero count", bus_req, 0);
      if (!bus_gnt)
        chk(bus_addr == 0 && !bus_we && bus_wdata == 0, "R7", "bus quiet",
            {bus_we, bus_addr, bus_wdata}, 0);
      if (bus_req && bus_gnt) begin
        if (!bus_we) begin
          chk(bus_addr == AW'(rd_ptr), "R4", "read addr", bus_addr, rd_ptr);
          pend = mem[bus_addr[7:0]];
          rd_ptr++;
        end else begin
          chk(bus_addr == AW'(wr_ptr), "R4", "write addr", bus_addr, wr_ptr);
          chk(bus_wdata == pend, "R4", "write data", bus_wdata, pend);
          mem[bus_addr[7:0]] = bus_wdata;
          wr_ptr++;
          after_wr = 1;
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] a, output logic [DW-1:0] v);
    cfg_addr = a;
    #1;
    v = cfg_rdata;
  endtask

  task automatic run_xfer(input int src, input int dst, input int n,
                          input bit rg, input bit meddle);
    logic [DW-1:0] v;
    int bad;
    bit done;
    for (int i = 0; i < 256; i++) mem[i] = DW'($urandom);
    for (int i = 0; i < 256; i++) snap[i] = mem[i];
    rd_ptr = src; wr_ptr = dst; rand_gnt = rg;
    cfg_write(2'd0, DW'(src));
    cfg_write(2'd1, DW'(dst));
    cfg_write(2'd2, DW'(n));
    cfg_write(2'd3, 16'h0001);
    cfg_read(2'd3, v);
    chk(v[0] == 1'b1, "R3", "busy after start", v[0], 1);
    if (meddle) begin
      cfg_write(2'd0, 16'h00F0);
      cfg_write(2'd1, 16'h00F8);
      cfg_write(2'd2, 16'h0003);
      cfg_write(2'd3, 16'h0001);
    end
    done = 0;
    for (int c = 0; c < 5000 && !done; c++) begin
      @(negedge clk);
      cfg_read(2'd3, v);
      done = (v[0] == 1'b0);
    end
    chk(done, "R9", "transfer finishes", done, 1);
    chk(v[1] == 1'b1, "R9", "irq at completion", v[1], 1);
    cfg_read(2'd0, v);
    chk(v == DW'(src + n), meddle ? "R10" : "R8", "src pointer", v, src + n);
    cfg_read(2'd1, v);
    chk(v == DW'(dst + n), meddle ? "R10" : "R8", "dst pointer", v, dst + n);
    cfg_read(2'd2, v);
    chk(v == 0, "R8", "count drained", v, 0);
    bad = 0;
    for (int i = 0; i < n; i++) if (mem[dst + i] != snap[src + i]) bad++;
    chk(bad == 0, "R4", "destination contents", bad, 0);
    chk(rd_ptr == src + n && wr_ptr == dst + n, "R4", "access counts", rd_ptr, src + n);
    repeat (3) @(negedge clk);
    cfg_write(2'd3, 16'h0000);
    cfg_read(2'd3, v);
    chk(v[1] == 1'b1, "R12", "irq held", v[1], 1);
    cfg_write(2'd3, 16'h0002);
    cfg_read(2'd3, v);
    chk(v[1] == 1'b0, "R12", "irq cleared", v[1], 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    cfg_read(2'd3, v);
    chk(v == 0 && !bus_req && !irq, "R1", "reset status", v, 0);
    cfg_read(2'd0, v);
    chk(v == 0, "R1", "reset src", v, 0);
    cfg_read(2'd2, v);
    chk(v == 0, "R1", "reset count", v, 0);
    // R2
    cfg_write(2'd0, 16'h1234);
    cfg_write(2'd1, 16'h0ABC);
    cfg_write(2'd2, 16'h0007);
    cfg_read(2'd0, v); chk(v == 16'h1234, "R2", "src readback", v, 16'h1234);
    cfg_read(2'd1, v); chk(v == 16'h0ABC, "R2", "dst readback", v, 16'h0ABC);
    cfg_read(2'd2, v); chk(v == 16'h0007, "R2", "count readback", v, 7);
    // R11
    cfg_write(2'd2, 16'h0000);
    no_req = 1;
    cfg_write(2'd3, 16'h0001);
    cfg_read(2'd3, v);
    chk(v[1:0] == 2'b10, "R11", "zero count status", v[1:0], 2);
    repeat (6) @(negedge clk);
    no_req = 0;
    cfg_write(2'd3, 16'h0002);
    cfg_read(2'd3, v);
    chk(v[1] == 1'b0, "R12", "clear after zero", v[1], 0);
    // directed transfers
    run_xfer(10, 150, 1, 0, 0);
    run_xfer(0, 128, 5, 0, 0);
    run_xfer(3, 140, 8, 1, 1);
    // random transfers
    for (int k = 0; k < 12; k++)
      run_xfer($urandom % 24, 128 + ($urandom % 24), 1 + ($urandom % 40), 1, (k % 4) == 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule